// File: doc/BRIEF.md
# Multiplexed Address/Data Pseudo-Static RAM Controller

This block lets a host issue single, untimed (asynchronous-mode) read and write accesses to a 1M x 16 pseudo-static RAM. The memory shares one 16-bit bus for the low address bits and the data word. The upper address bits go out on their own pins. The host sees a valid/ready request port that carries a word address, write data, two byte enables and a direction flag. A read returns its word through a one-cycle response strobe.

Each access follows a fixed sequence. First comes an address phase in which the address-valid strobe is low. Then the bus is released for one cycle. A read follows with an output-enable window; a write follows with a data window and then a hold cycle in which every strobe is raised while the data word stays on the bus. A recovery gap with chip enable high closes the access. Every window length is a parameter counted in clock cycles. The memory clock pin stays at a fixed level, and the memory's wait output is not used.

Top module: `psram_admux_ctrl`

## Requirements
- R1: While reset is held and right after it, all six memory strobes (chip enable, address valid, output enable, write enable, upper lane, lower lane; all active-low) read 1, `mem_ad_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A transfer starts in the cycle after `req_valid && req_ready`. Chip enable and address valid are low for exactly ADDR_CYC cycles. During those cycles `mem_ad_oe` is 1, `mem_ad_out` carries `req_addr[15:0]`, `mem_a_hi` carries `req_addr[19:16]`, and output enable is high.
- R3: In a read, address valid rises and one cycle with the bus released follows. Output enable is then low for exactly ACC_CYC cycles. `rsp_rdata` takes the value of `mem_ad_in` from the last of those cycles, and `rsp_valid` is a single-cycle pulse in the cycle after it. Responses arrive in request order.
- R4: In a write, write enable is low from the first address cycle onward. After the released-bus cycle, `mem_ad_out` carries the write word with `mem_ad_oe` 1 for exactly WE_CYC cycles. Output enable stays high for the whole write.
- R5: A write ends with chip enable, write enable and both lane strobes rising in the same cycle. In that cycle `mem_ad_oe` is still 1 and `mem_ad_out` still holds the write word.
- R6: During a transfer the upper lane strobe is `!req_be[1]` and the lower lane strobe is `!req_be[0]`. Both are 1 whenever chip enable is 1. A write with `req_be` = 2'b00 leaves the stored word unchanged.
- R7: Write enable is low for ADDR_CYC+1+WE_CYC cycles per write. That count must not exceed WE_MAX_CYC, and elaboration is refused if it does.
- R8: `mem_clk` is constant at the CLK_LEVEL parameter value (default 0) at all times.
- R9: `mem_wait` has no effect: read data and strobe timing do not change when it toggles.
- R10: After chip enable rises, it stays high for at least REC_CYC cycles before the next transfer. `req_ready` is 0 from acceptance until that gap has ended.
- R11: The controller never drives the bus while output enable is low. `mem_ad_oe` is 0 in the cycle before output enable falls and in the cycle after address valid rises.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| rsp_valid | output | 1 | One-cycle strobe: read data valid |
| rsp_rdata | output | 16 | Read word |
| mem_clk | output | 1 | Memory clock, held constant |
| mem_ce_n | output | 1 | Chip enable, active-low |
| mem_adv_n | output | 1 | Address valid, active-low |
| mem_oe_n | output | 1 | Output enable, active-low |
| mem_we_n | output | 1 | Write enable, active-low |
| mem_ub_n | output | 1 | Upper byte lane, active-low |
| mem_lb_n | output | 1 | Lower byte lane, active-low |
| mem_a_hi | output | 4 | Upper address bits |
| mem_ad_out | output | 16 | Value driven onto the shared bus |
| mem_ad_oe | output | 1 | 1 = controller drives the shared bus |
| mem_ad_in | input | 16 | Value sampled from the shared bus |
| mem_wait | input | 1 | Memory wait output, not used |

## Verification
Two functions can land in the same cycle: the end of one transfer and the acceptance of the next. When the host keeps requests queued, the recovery gap closes in the same edge where a new address phase could open, and the write hold cycle could merge with the next address drive. The bench issues requests back to back with no idle time in the driver. A memory model watches every strobe edge and measures the high time of chip enable before each fall, whether the bus was released before output enable fell, and whether the write word was still on the bus when the strobes rose. The read data the model returns is valid only in the last output-enable cycle, so a sample taken one cycle early or late returns a marker value and the scoreboard reports it.

// File: rtl/psram_admux_pkg.sv
package psram_admux_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_TURN,
      ST_READ,
      ST_WDATA,
      ST_WHOLD,
      ST_RECOV
   } seq_state_e;

   // registered drive bundle towards the memory pins
   typedef struct packed {
      logic ce_n;
      logic adv_n;
      logic oe_n;
      logic we_n;
      logic ub_n;
      logic lb_n;
      logic drv;
      logic sel_data;
   } strobe_t;

   localparam strobe_t STRB_QUIET = '{
      ce_n: 1'b1, adv_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
      ub_n: 1'b1, lb_n: 1'b1, drv: 1'b0, sel_data: 1'b0
   };

endpackage

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/psram_seq_fsm.sv
module psram_seq_fsm
   import psram_admux_pkg::*;
#(
   parameter int ADDR_CYC = 2,
   parameter int ACC_CYC  = 4,
   parameter int WE_CYC   = 3,
   parameter int REC_CYC  = 2,
   parameter int CNT_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             wr_q,
   input  logic             wr_nx,
   input  logic [1:0]       be_nx,
   input  logic             tmr_done,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             req_ready,
   output logic             sample_rd,
   output strobe_t          strb_q
);

   seq_state_e state_q, state_d;

   function automatic logic [CNT_W-1:0] len_of(input seq_state_e st);
      case (st)
         ST_ADDR:  return CNT_W'(ADDR_CYC - 1);
         ST_READ:  return CNT_W'(ACC_CYC - 1);
         ST_WDATA: return CNT_W'(WE_CYC - 1);
         ST_RECOV: return CNT_W'(REC_CYC - 1);
         default:  return '0;
      endcase
   endfunction

   function automatic strobe_t drive_of(input seq_state_e st, input logic wr,
                                        input logic [1:0] be);
      strobe_t s;
      s = STRB_QUIET;
      case (st)
         ST_ADDR: begin
            s.ce_n  = 1'b0;
            s.adv_n = 1'b0;
            s.we_n  = !wr;
            s.ub_n  = !be[1];
            s.lb_n  = !be[0];
            s.drv   = 1'b1;
         end
         ST_TURN: begin
            s.ce_n  = 1'b0;
            s.we_n  = !wr;
            s.ub_n  = !be[1];
            s.lb_n  = !be[0];
         end
         ST_READ: begin
            s.ce_n  = 1'b0;
            s.oe_n  = 1'b0;
            s.ub_n  = !be[1];
            s.lb_n  = !be[0];
         end
         ST_WDATA: begin
            s.ce_n     = 1'b0;
            s.we_n     = 1'b0;
            s.ub_n     = !be[1];
            s.lb_n     = !be[0];
            s.drv      = 1'b1;
            s.sel_data = 1'b1;
         end
         ST_WHOLD: begin
            s.drv      = 1'b1;
            s.sel_data = 1'b1;
         end
         default: s = STRB_QUIET;
      endcase
      return s;
   endfunction

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (start)    state_d = ST_ADDR;
         ST_ADDR:  if (tmr_done) state_d = ST_TURN;
         ST_TURN:  if (tmr_done) state_d = wr_q ? ST_WDATA : ST_READ;
         ST_READ:  if (tmr_done) state_d = ST_RECOV;
         ST_WDATA: if (tmr_done) state_d = ST_WHOLD;
         ST_WHOLD: if (tmr_done) state_d = ST_RECOV;
         ST_RECOV: if (tmr_done) state_d = ST_IDLE;
         default:                state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         strb_q  <= STRB_QUIET;
      end else begin
         state_q <= state_d;
         strb_q  <= drive_of(state_d, wr_nx, be_nx);
      end
   end

   assign tmr_load  = (state_d != state_q);
   assign tmr_val   = len_of(state_d);
   assign req_ready = (state_q == ST_IDLE);
   assign sample_rd = (state_q == ST_READ) && tmr_done;

endmodule

// File: rtl/psram_ad_bus.sv
module psram_ad_bus #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter int HI_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_be,
   input  logic              req_write,
   input  logic              sel_data,
   input  logic              sample_rd,
   input  logic [DATA_W-1:0] ad_in,
   output logic              wr_q,
   output logic [1:0]        be_q,
   output logic [DATA_W-1:0] ad_out,
   output logic [HI_W-1:0]   a_hi,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
         wr_q    <= 1'b0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         be_q    <= req_be;
         wr_q    <= req_write;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= sample_rd;
         if (sample_rd) rsp_rdata <= ad_in;
      end
   end

   assign ad_out = sel_data ? wdata_q : addr_q[DATA_W-1:0];

   generate
      if (ADDR_W > DATA_W) begin : g_hi_bits
         assign a_hi = addr_q[ADDR_W-1:DATA_W];
      end else begin : g_no_hi_bits
         assign a_hi = '0;
      end
   endgenerate

endmodule

// File: rtl/psram_admux_ctrl.sv
module psram_admux_ctrl
   import psram_admux_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 16,
   parameter int ADDR_CYC   = 2,
   parameter int ACC_CYC    = 4,
   parameter int WE_CYC     = 3,
   parameter int REC_CYC    = 2,
   parameter int WE_MAX_CYC = 8,
   parameter bit CLK_LEVEL  = 1'b0,
   localparam int HI_W      = (ADDR_W > DATA_W) ? ADDR_W - DATA_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_be,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_clk,
   output logic              mem_ce_n,
   output logic              mem_adv_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              mem_ub_n,
   output logic              mem_lb_n,
   output logic [HI_W-1:0]   mem_a_hi,
   output logic [DATA_W-1:0] mem_ad_out,
   output logic              mem_ad_oe,
   input  logic [DATA_W-1:0] mem_ad_in,
   input  logic              mem_wait
);

   localparam int WE_LOW_CYC = ADDR_CYC + 1 + WE_CYC;
   localparam int MAX_LEN_A  = (ADDR_CYC > ACC_CYC) ? ADDR_CYC : ACC_CYC;
   localparam int MAX_LEN_B  = (WE_CYC > REC_CYC) ? WE_CYC : REC_CYC;
   localparam int MAX_LEN    = (MAX_LEN_A > MAX_LEN_B) ? MAX_LEN_A : MAX_LEN_B;
   localparam int CNT_W      = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

   // elaboration-time parameter checks
   generate
      if (ADDR_CYC < 1 || ACC_CYC < 1 || WE_CYC < 1 || REC_CYC < 1) begin : g_bad_len
         $error("psram_admux_ctrl: every phase length must be at least one cycle");
      end
      if (WE_LOW_CYC > WE_MAX_CYC) begin : g_bad_we
         $error("psram_admux_ctrl: write-enable low span exceeds WE_MAX_CYC");
      end
      if (ADDR_W < DATA_W || (DATA_W % 2) != 0) begin : g_bad_width
         $error("psram_admux_ctrl: address must cover the bus, data must split in two lanes");
      end
   endgenerate

   logic             start;
   logic             wr_q, wr_nx;
   logic [1:0]       be_q, be_nx;
   logic             tmr_done, tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             sample_rd;
   strobe_t          strb_q;
   logic             unused_wait;

   assign start       = req_valid && req_ready;
   assign wr_nx       = start ? req_write : wr_q;
   assign be_nx       = start ? req_be : be_q;
   assign unused_wait = mem_wait;

   psram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   psram_seq_fsm #(
      .ADDR_CYC (ADDR_CYC),
      .ACC_CYC  (ACC_CYC),
      .WE_CYC   (WE_CYC),
      .REC_CYC  (REC_CYC),
      .CNT_W    (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .wr_q      (wr_q),
      .wr_nx     (wr_nx),
      .be_nx     (be_nx),
      .tmr_done  (tmr_done),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .req_ready (req_ready),
      .sample_rd (sample_rd),
      .strb_q    (strb_q)
   );

   psram_ad_bus #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .HI_W   (HI_W)
   ) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (start),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_be    (req_be),
      .req_write (req_write),
      .sel_data  (strb_q.sel_data),
      .sample_rd (sample_rd),
      .ad_in     (mem_ad_in),
      .wr_q      (wr_q),
      .be_q      (be_q),
      .ad_out    (mem_ad_out),
      .a_hi      (mem_a_hi),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   assign mem_clk   = CLK_LEVEL;
   assign mem_ce_n  = strb_q.ce_n;
   assign mem_adv_n = strb_q.adv_n;
   assign mem_oe_n  = strb_q.oe_n;
   assign mem_we_n  = strb_q.we_n;
   assign mem_ub_n  = strb_q.ub_n;
   assign mem_lb_n  = strb_q.lb_n;
   assign mem_ad_oe = strb_q.drv;

endmodule

// File: rtl/psram_admux_ctrl_chk.sv
module psram_admux_ctrl_chk #(
   parameter int DATA_W     = 16,
   parameter int REC_CYC    = 2,
   parameter int WE_MAX_CYC = 8,
   parameter bit CLK_LEVEL  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              mem_clk,
   input logic              mem_ce_n,
   input logic              mem_adv_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_ub_n,
   input logic              mem_lb_n,
   input logic              mem_ad_oe,
   input logic [DATA_W-1:0] mem_ad_out
);

   logic [15:0] we_lo_cnt;
   logic [15:0] ce_hi_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_lo_cnt <= '0;
         ce_hi_cnt <= 16'(REC_CYC);
      end else begin
         if (!mem_we_n) we_lo_cnt <= (we_lo_cnt == 16'hFFFF) ? we_lo_cnt : we_lo_cnt + 1'b1;
         else           we_lo_cnt <= '0;
         if (mem_ce_n)  ce_hi_cnt <= (ce_hi_cnt == 16'hFFFF) ? ce_hi_cnt : ce_hi_cnt + 1'b1;
         else           ce_hi_cnt <= '0;
      end
   end

   a_r2_oe_high_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_adv_n |-> (mem_oe_n && mem_ad_oe && !mem_ce_n));

   a_r3_rsp_single_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(!mem_oe_n) && mem_oe_n));

   a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r5_strobes_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> ($rose(mem_ce_n) && mem_ub_n && mem_lb_n));

   a_r5_data_held_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_we_n) && $past(mem_ad_oe)) |-> (mem_ad_oe && $stable(mem_ad_out)));

   a_r6_lanes_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> (mem_ub_n && mem_lb_n && mem_we_n && mem_oe_n && mem_adv_n));

   a_r7_we_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (we_lo_cnt < 16'(WE_MAX_CYC)));

   a_r8_clk_constant: assert property (@(posedge clk) disable iff (!rst_n)
      mem_clk == CLK_LEVEL);

   a_r10_recovery_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce_n) |-> (ce_hi_cnt >= 16'(REC_CYC)));

   a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r11_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ad_oe |-> mem_oe_n);

   a_r11_release_before_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> $past(!mem_ad_oe));

   a_r11_release_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_adv_n) |-> !mem_ad_oe);

endmodule

bind psram_admux_ctrl psram_admux_ctrl_chk #(
   .DATA_W     (DATA_W),
   .REC_CYC    (REC_CYC),
   .WE_MAX_CYC (WE_MAX_CYC),
   .CLK_LEVEL  (CLK_LEVEL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .mem_clk    (mem_clk),
   .mem_ce_n   (mem_ce_n),
   .mem_adv_n  (mem_adv_n),
   .mem_oe_n   (mem_oe_n),
   .mem_we_n   (mem_we_n),
   .mem_ub_n   (mem_ub_n),
   .mem_lb_n   (mem_lb_n),
   .mem_ad_oe  (mem_ad_oe),
   .mem_ad_out (mem_ad_out)
);

// File: tb/psram_admux_ctrl_tb.sv
module psram_admux_ctrl_tb;

   localparam int ADDR_CYC = 2;
   localparam int ACC_CYC  = 4;
   localparam int WE_CYC   = 3;
   localparam int REC_CYC  = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic        mem_clk, mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
   logic [3:0]  mem_a_hi;
   logic [15:0] mem_ad_out;
   logic        mem_ad_oe;
   logic [15:0] mem_ad_in = 16'hDEAD;
   logic        mem_wait = 1'b0;

   psram_admux_ctrl #(
      .ADDR_CYC(ADDR_CYC), .ACC_CYC(ACC_CYC), .WE_CYC(WE_CYC), .REC_CYC(REC_CYC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_clk(mem_clk), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n),
      .mem_lb_n(mem_lb_n), .mem_a_hi(mem_a_hi), .mem_ad_out(mem_ad_out),
      .mem_ad_oe(mem_ad_oe), .mem_ad_in(mem_ad_in), .mem_wait(mem_wait)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bench expectation store and memory model store
   logic [15:0] shadow [int];
   logic [15:0] ram    [int];
   logic [15:0] exp_q [$];
   string       tag_q [$];

   function automatic logic [15:0] sh_rd(input int a);
      return shadow.exists(a) ? shadow[a] : 16'h0000;
   endfunction
   function automatic logic [15:0] ram_rd(input int a);
      return ram.exists(a) ? ram[a] : 16'h0000;
   endfunction

   logic        cur_write = 1'b0;
   logic [19:0] cur_addr  = '0;
   logic [15:0] cur_wdata = '0;
   logic [1:0]  cur_be    = '0;
   bit          wiggle    = 1'b0;

   // protocol flags gathered over the run
   int clk_bad = 0, bus_bad = 0, ready_bad = 0, oe_in_write = 0, wdata_bad = 0;

   // memory model and protocol monitor, evaluated mid-cycle
   logic prev_ce = 1'b1, prev_adv = 1'b1, prev_oe = 1'b1, prev_we = 1'b1;
   logic prev_ub = 1'b1, prev_lb = 1'b1, prev_ad_oe = 1'b0;
   int   adv_run = 0, oe_run = 0, we_run = 0, wd_run = 0, ce_hi = 100;
   logic [19:0] lat = '0;

   always @(negedge clk) begin
      if (wiggle) mem_wait = ~mem_wait;
      if (rst_n) begin
         if (mem_clk !== 1'b0) clk_bad++;
         if (mem_ad_oe && !mem_oe_n) bus_bad++;
         if (!mem_oe_n && prev_oe && prev_ad_oe) bus_bad++;
         if (!mem_ce_n && req_ready) ready_bad++;
         if (!mem_ce_n && cur_write && !mem_oe_n) oe_in_write++;

         if (!mem_ce_n && prev_ce)
            check(ce_hi >= REC_CYC + 1, "R10 chip-enable high gap", ce_hi, REC_CYC + 1);
         ce_hi = mem_ce_n ? ce_hi + 1 : 0;

         if (!mem_adv_n && !mem_ce_n) begin
            if (adv_run == 0) begin
               check({mem_ub_n, mem_lb_n} == ~cur_be, "R6 lane strobes",
                     {mem_ub_n, mem_lb_n}, ~cur_be);
               check(mem_oe_n && mem_ad_oe, "R2 oe high, bus driven",
                     {mem_oe_n, mem_ad_oe}, 2'b11);
            end
            adv_run++;
            lat = {mem_a_hi, mem_ad_out};
         end
         if (mem_adv_n && !prev_adv) begin
            check(adv_run == ADDR_CYC, "R2 address phase length", adv_run, ADDR_CYC);
            check(lat == cur_addr, "R2 latched address", lat, cur_addr);
            check(!mem_ad_oe, "R11 bus released after address", mem_ad_oe, 0);
            adv_run = 0;
         end

         if (!mem_oe_n && !mem_ce_n) begin
            oe_run++;
            mem_ad_in = (oe_run == ACC_CYC) ? ram_rd(int'(lat)) : 16'hDEAD;
         end else begin
            mem_ad_in = 16'hDEAD;
         end
         if (mem_oe_n && !prev_oe) begin
            check(oe_run == ACC_CYC, "R3 output-enable window", oe_run, ACC_CYC);
            oe_run = 0;
         end

         if (!mem_we_n) we_run++;
         if (!mem_we_n && mem_adv_n && mem_ad_oe) begin
            wd_run++;
            if (mem_ad_out !== cur_wdata) wdata_bad++;
         end
         if (mem_ce_n && !prev_ce && !prev_we) begin
            check(mem_we_n && mem_ub_n && mem_lb_n, "R5 strobes rise together",
                  {mem_we_n, mem_ub_n, mem_lb_n}, 3'b111);
            check(mem_ad_oe && mem_ad_out == cur_wdata, "R5 data held at release",
                  mem_ad_out, cur_wdata);
            check(we_run == ADDR_CYC + 1 + WE_CYC, "R7 write-enable low span",
                  we_run, ADDR_CYC + 1 + WE_CYC);
            check(wd_run == WE_CYC, "R4 write data window", wd_run, WE_CYC);
            begin
               logic [15:0] old;
               old = ram_rd(int'(lat));
               ram[int'(lat)] = {prev_ub ? old[15:8] : mem_ad_out[15:8],
                                 prev_lb ? old[7:0]  : mem_ad_out[7:0]};
            end
         end
         if (mem_ce_n) begin
            we_run = 0;
            wd_run = 0;
         end

         if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R3 unexpected response", rsp_rdata, 0);
            end else begin
               logic [15:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(rsp_rdata == e, t, rsp_rdata, e);
            end
         end
      end
      prev_ce = mem_ce_n;  prev_adv = mem_adv_n; prev_oe = mem_oe_n;
      prev_we = mem_we_n;  prev_ub = mem_ub_n;   prev_lb = mem_lb_n;
      prev_ad_oe = mem_ad_oe;
   end

   // driver: one request; expected read values go to the scoreboard queue
   task automatic xfer(input logic wr, input logic [19:0] a, input logic [15:0] d,
                       input logic [1:0] be, input string tag);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      cur_write = wr; cur_addr = a; cur_wdata = d; cur_be = be;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      if (wr) begin
         logic [15:0] old;
         old = sh_rd(int'(a));
         shadow[int'(a)] = {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
      end else begin
         exp_q.push_back(sh_rd(int'(a)));
         tag_q.push_back(tag);
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: quiet pins during reset
      check({mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} == 6'h3F,
            "R1 strobes high in reset",
            {mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 6'h3F);
      check({mem_ad_oe, req_ready, rsp_valid} == 3'b010, "R1 bus, ready, response",
            {mem_ad_oe, req_ready, rsp_valid}, 3'b010);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && mem_ce_n && !mem_ad_oe, "R1 state after reset",
            {req_ready, mem_ce_n, mem_ad_oe}, 3'b110);

      // full-word writes and read-back, address boundaries
      xfer(1'b1, 20'h12345, 16'hA5C3, 2'b11, "R4");
      xfer(1'b1, 20'hFFFFF, 16'h0F0F, 2'b11, "R4");
      xfer(1'b1, 20'h00000, 16'hFFFF, 2'b11, "R4");
      xfer(1'b0, 20'h12345, 16'h0, 2'b11, "R3 read word mid range");
      xfer(1'b0, 20'hFFFFF, 16'h0, 2'b11, "R2 read top address");
      xfer(1'b0, 20'h00000, 16'h0, 2'b11, "R2 read address zero");

      // byte lanes
      xfer(1'b1, 20'h12345, 16'h7777, 2'b01, "R6");
      xfer(1'b0, 20'h12345, 16'h0, 2'b11, "R6 lower lane only");
      xfer(1'b1, 20'h12345, 16'h1111, 2'b10, "R6");
      xfer(1'b0, 20'h12345, 16'h0, 2'b11, "R6 upper lane only");
      xfer(1'b1, 20'h12345, 16'h9999, 2'b00, "R6");
      xfer(1'b0, 20'h12345, 16'h0, 2'b11, "R6 no lane leaves word");

      // wait pin toggling during reads and a write
      wiggle = 1'b1;
      xfer(1'b1, 20'hABCDE, 16'h5A5A, 2'b11, "R9");
      xfer(1'b0, 20'hABCDE, 16'h0, 2'b11, "R9 read with wait toggling");
      xfer(1'b0, 20'hFFFFF, 16'h0, 2'b11, "R9 read with wait toggling");
      wiggle = 1'b0;

      // back-to-back traffic, alternating direction
      for (int i = 0; i < 6; i++) begin
         xfer(1'b1, 20'(20'h40000 + i * 20'h01111), 16'(16'h1000 + i * 16'h0203), 2'b11, "R10");
         xfer(1'b0, 20'(20'h40000 + i * 20'h01111), 16'h0, 2'b11, "R10 back-to-back read");
      end

      repeat (40) @(negedge clk);
      check(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);
      check(clk_bad == 0, "R8 memory clock constant", clk_bad, 0);
      check(bus_bad == 0, "R11 bus released around reads", bus_bad, 0);
      check(ready_bad == 0, "R10 ready low during transfer", ready_bad, 0);
      check(oe_in_write == 0, "R4 output enable high in writes", oe_in_write, 0);
      check(wdata_bad == 0, "R4 write word on bus", wdata_bad, 0);
      finish_run();
   end

endmodule